// File: doc/BRIEF.md
# Video Fetch Phase Sequencer

This block converts CPU opcode fetches into character fetches for a small home-computer display. It runs on a fast clock at twice the CPU clock. When /M1 goes active, a 3-bit phase counter restarts. The counter then walks through the eight half-T-state phases of the fetch, from the second half of T1 to the first half of the next T1. The phases are numbered 0 to 7, and the end of T2 is the clock edge that closes phase 2. Because the counter alone places each strobe, the block needs no memory-request or refresh strobes from the CPU.

The block only acts on a fetch inside the video address window, where both top address bits are high. On such a fetch it forces a NOP onto the CPU data bus around the end of T2. It captures the memory byte into a character latch at that same edge. During T4, the refresh part of the cycle, it enables the latch output. In text mode that output addresses the font ROM. In bitmap graphics mode the font ROM stays disabled and the latched byte goes straight onto the data bus. A display line chains 32 such fetches, and each fetch's last phase is the first half of T1 of the next fetch.

Top module: `vidfetch_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no /M1 activity, all strobe outputs are low and `char_code` is 0.
- R2: A start occurs on the clock edge where `m1_n` is sampled low after having been sampled high. It begins phase 0 for the following cycle. The phase then advances by one per fast clock to phase 7, and the block returns to idle. Holding `m1_n` low does not start a second pass.
- R3: A fetch is video only if `addr_hi` (bit 1 = A15, bit 0 = A14) equals 2'b11 at the start edge. For any other value, no strobe asserts during the pass and `char_code` keeps its value.
- R4: On a video fetch, `latch_ld` is high in phase 2 only. `char_code` takes the value of `mem_data` present on the edge that ends phase 2, and it holds that value until the next load.
- R5: On a video fetch, `nop_oe` (the request to drive 8'h00 onto the CPU bus) is high in phases 2 and 3 only, one fast period either side of the end of T2.
- R6: On a video fetch, `latch_oe` is high in phases 5 and 6 only, and it is never high in the same cycle as `nop_oe`.
- R7: In text mode (`gfx_sel` 0 at start), `font_en` equals `latch_oe` and `bitmap_oe` stays low.
- R8: In graphics mode (`gfx_sel` 1 at start), `bitmap_oe` equals `latch_oe` and `font_en` stays low.
- R9: A start edge during phase 7 restarts at phase 0 on the next cycle with no idle cycle, so back-to-back fetches repeat the same timing.
- R10: `addr_hi` and `gfx_sel` are captured at the start edge. Changes to them later in the pass have no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock at twice the CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m1_n | input | 1 | Active-low opcode fetch indication from the CPU |
| addr_hi | input | 2 | Top address bits {A15, A14} |
| mem_data | input | 8 | Memory-side data bus |
| gfx_sel | input | 1 | 1 selects bitmap graphics mode, 0 selects text mode |
| nop_oe | output | 1 | Drive an all-zero byte onto the CPU data bus |
| latch_ld | output | 1 | Character latch load strobe |
| latch_oe | output | 1 | Character latch output enable |
| font_en | output | 1 | Font ROM enable (text mode) |
| bitmap_oe | output | 1 | Drive the latched byte onto the data bus (graphics mode) |
| char_code | output | 8 | Latched character or bitmap byte |

## Verification
If the phase counter is off by one, every strobe edge moves by a whole fast-clock period on the first fetch after the fault. The bench would see it within the next four cycles, because it compares each strobe in each phase. If the video or mode flag is captured wrongly, a strobe appears in a non-video pass or on the wrong ROM/bus enable, or `char_code` changes when it should not. A bad end-of-pass or restart decision shows up either as strobes that persist into idle cycles or as a 32-fetch chain that drifts out of phase.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  // Strobe bundle produced by the phase decoder
  typedef struct packed {
    logic nop;   // force zero opcode onto CPU bus
    logic ld;    // capture memory byte into character latch
    logic oe;    // character latch output enable
    logic font;  // font ROM enable (text)
    logic bmp;   // latched byte onto data bus (graphics)
  } strobe_t;

  // Value of {A15, A14} that marks a video fetch
  localparam logic [1:0] VID_WINDOW = 2'b11;

endpackage

// File: rtl/vfs_m1_sample.sv
module vfs_m1_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  output logic start
);

  logic m1_q;
  logic m1_d;

  always_comb begin
    m1_d  = m1_n;
    start = m1_q & ~m1_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m1_q <= 1'b1;
    else        m1_q <= m1_d;
  end

  // R2: a start is one edge wide even if m1_n stays low
  p_single_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

endmodule

// File: rtl/vfs_phase.sv
module vfs_phase
  import vfs_pkg::*;
#(
  parameter int PH_W = 3,
  parameter logic [PH_W-1:0] LAST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      addr_hi,
  input  logic            gfx_sel,
  output logic            busy,
  output logic [PH_W-1:0] phase,
  output logic            vid,
  output logic            gfx
);

  logic            busy_d;
  logic [PH_W-1:0] phase_d;
  logic            vid_d;
  logic            gfx_d;
  logic            at_last;

  always_comb begin
    at_last = (phase == LAST);
    busy_d  = busy;
    phase_d = phase;
    vid_d   = vid;
    gfx_d   = gfx;
    if (start) begin
      busy_d  = 1'b1;
      phase_d = '0;
      vid_d   = (addr_hi == VID_WINDOW);
      gfx_d   = gfx_sel;
    end else if (busy) begin
      if (at_last) begin
        busy_d  = 1'b0;
        phase_d = '0;
        vid_d   = 1'b0;
      end else begin
        phase_d = phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
      vid   <= 1'b0;
      gfx   <= 1'b0;
    end else begin
      busy  <= busy_d;
      phase <= phase_d;
      vid   <= vid_d;
      gfx   <= gfx_d;
    end
  end

  // R2: phase steps by one while a pass runs
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && phase != LAST) |=> (busy && phase == PH_W'($past(phase) + 1'b1)));

  // R2: pass ends in idle after the last phase
  p_end_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && phase == LAST) |=> !busy);

  // R9: a start always lands in phase zero
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && phase == '0));

  // R10: captured attributes hold during a pass
  p_attr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && phase != LAST) |=> ($stable(vid) && $stable(gfx)));

endmodule

// File: rtl/vfs_strobe.sv
module vfs_strobe
  import vfs_pkg::*;
#(
  parameter int PH_W = 3,
  parameter logic [PH_W-1:0] LD_PH     = 3'd2,
  parameter logic [PH_W-1:0] NOP_FIRST = 3'd2,
  parameter logic [PH_W-1:0] NOP_LAST  = 3'd3,
  parameter logic [PH_W-1:0] OE_FIRST  = 3'd5,
  parameter logic [PH_W-1:0] OE_LAST   = 3'd6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic [PH_W-1:0] phase,
  input  logic            vid,
  input  logic            gfx,
  output strobe_t         stb
);

  logic act;

  always_comb begin
    act      = busy & vid;
    stb.nop  = act & (phase >= NOP_FIRST) & (phase <= NOP_LAST);
    stb.ld   = act & (phase == LD_PH);
    stb.oe   = act & (phase >= OE_FIRST) & (phase <= OE_LAST);
    stb.font = stb.oe & ~gfx;
    stb.bmp  = stb.oe & gfx;
  end

  // R6: bus contention guard between forced NOP and latch output
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.oe && stb.nop));

  // R7: font enable and bitmap drive never overlap
  p_mode_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.font, stb.bmp}));

  // R5: the load edge lies inside the forced-NOP window
  p_ld_in_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ld |-> stb.nop);

endmodule

// File: rtl/vfs_latch.sv
module vfs_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_d;

  always_comb begin
    q_d = ld ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R4: capture on the load edge
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d)));

  // R4: no change without a load
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

endmodule

// File: rtl/vidfetch_seq.sv
module vidfetch_seq
  import vfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PHASES = 8
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              m1_n,
  input  logic [1:0]        addr_hi,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              gfx_sel,
  output logic              nop_oe,
  output logic              latch_ld,
  output logic              latch_oe,
  output logic              font_en,
  output logic              bitmap_oe,
  output logic [DATA_W-1:0] char_code
);

  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  // reset: asynchronous assert, synchronous release
  logic rs_a, rs_b;
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  logic            start;
  logic            busy;
  logic [PH_W-1:0] phase;
  logic            vid;
  logic            gfx;
  strobe_t         stb;

  vfs_m1_sample u_m1 (
    .clk   (clk2x),
    .rst_n (rs_b),
    .m1_n  (m1_n),
    .start (start)
  );

  vfs_phase #(.PH_W(PH_W), .LAST(LAST)) u_phase (
    .clk     (clk2x),
    .rst_n   (rs_b),
    .start   (start),
    .addr_hi (addr_hi),
    .gfx_sel (gfx_sel),
    .busy    (busy),
    .phase   (phase),
    .vid     (vid),
    .gfx     (gfx)
  );

  vfs_strobe #(
    .PH_W      (PH_W),
    .LD_PH     (PH_W'(2)),
    .NOP_FIRST (PH_W'(2)),
    .NOP_LAST  (PH_W'(3)),
    .OE_FIRST  (PH_W'(5)),
    .OE_LAST   (PH_W'(6))
  ) u_strobe (
    .clk   (clk2x),
    .rst_n (rs_b),
    .busy  (busy),
    .phase (phase),
    .vid   (vid),
    .gfx   (gfx),
    .stb   (stb)
  );

  vfs_latch #(.DW(DATA_W)) u_latch (
    .clk   (clk2x),
    .rst_n (rs_b),
    .ld    (stb.ld),
    .d     (mem_data),
    .q     (char_code)
  );

  always_comb begin
    nop_oe    = stb.nop;
    latch_ld  = stb.ld;
    latch_oe  = stb.oe;
    font_en   = stb.font;
    bitmap_oe = stb.bmp;
  end

  // R3: no strobe of any kind outside a video pass
  p_window_r3: assert property (@(posedge clk2x) disable iff (!rs_b)
    (!busy || !vid) |-> !(nop_oe || latch_ld || latch_oe));

endmodule

// File: tb/tb_vidfetch_seq.sv
module tb_vidfetch_seq;

  localparam int CLK_P = 10;

  logic       clk2x = 1'b0;
  logic       rst_n;
  logic       m1_n;
  logic [1:0] addr_hi;
  logic [7:0] mem_data;
  logic       gfx_sel;
  logic       nop_oe, latch_ld, latch_oe, font_en, bitmap_oe;
  logic [7:0] char_code;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_char;

  always #(CLK_P/2) clk2x = ~clk2x;

  vidfetch_seq dut (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .m1_n      (m1_n),
    .addr_hi   (addr_hi),
    .mem_data  (mem_data),
    .gfx_sel   (gfx_sel),
    .nop_oe    (nop_oe),
    .latch_ld  (latch_ld),
    .latch_oe  (latch_oe),
    .font_en   (font_en),
    .bitmap_oe (bitmap_oe),
    .char_code (char_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "nop_oe idle",    nop_oe,    0);
    chk(req, "latch_ld idle",  latch_ld,  0);
    chk(req, "latch_oe idle",  latch_oe,  0);
    chk(req, "font_en idle",   font_en,   0);
    chk(req, "bitmap_oe idle", bitmap_oe, 0);
    chk(req, "char_code idle", char_code, exp_char);
  endtask

  // Caller drives m1_n low with the fetch attributes at a falling edge.
  // Returns at the falling edge inside phase 7.
  task automatic run_pass(input logic [1:0] a, input logic [7:0] d, input logic g,
                          input bit hold_low);
    bit v;
    v = (a == 2'b11);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk2x);
      @(negedge clk2x);
      if (v && i == 3) exp_char = d;
      chk(v ? "R5" : "R3", $sformatf("nop_oe ph%0d", i),   nop_oe,   v && (i == 2 || i == 3));
      chk(v ? "R4" : "R3", $sformatf("latch_ld ph%0d", i), latch_ld, v && (i == 2));
      chk(v ? "R6" : "R3", $sformatf("latch_oe ph%0d", i), latch_oe, v && (i == 5 || i == 6));
      chk("R7", $sformatf("font_en ph%0d", i),   font_en,   v && !g && (i == 5 || i == 6));
      chk("R8", $sformatf("bitmap_oe ph%0d", i), bitmap_oe, v && g && (i == 5 || i == 6));
      chk(v ? "R4" : "R3", $sformatf("char_code ph%0d", i), char_code, exp_char);
      if (i == 3) begin
        if (!hold_low) m1_n = 1'b1;
        mem_data = ~d;        // later bus values must not be captured (R4)
        addr_hi  = ~a;        // R10: attributes changed mid-pass
        gfx_sel  = ~g;
      end
    end
  endtask

  task automatic begin_fetch(input logic [1:0] a, input logic [7:0] d, input logic g);
    m1_n     = 1'b0;
    addr_hi  = a;
    mem_data = d;
    gfx_sel  = g;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    m1_n     = 1'b1;
    addr_hi  = 2'b00;
    mem_data = 8'h00;
    gfx_sel  = 1'b0;
    exp_char = 8'h00;
    repeat (3) @(negedge clk2x);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk2x);
    chk_idle("R1");

    // Sweep every window code and mode with several data bytes
    for (int a = 0; a < 4; a++) begin
      for (int g = 0; g < 2; g++) begin
        for (int k = 0; k < 3; k++) begin
          logic [7:0] d;
          d = (k == 0) ? 8'hA5 : (k == 1) ? 8'hFF : 8'(a * 37 + g * 91 + 5);
          begin_fetch(2'(a), d, g[0]);
          run_pass(2'(a), d, g[0], 1'b0);
          @(posedge clk2x);
          @(negedge clk2x);
          chk_idle("R2");
          @(negedge clk2x);
        end
      end
    end

    // R2: m1_n held low through and beyond the pass starts only one pass
    begin_fetch(2'b11, 8'h3C, 1'b0);
    run_pass(2'b11, 8'h3C, 1'b0, 1'b1);
    for (int j = 0; j < 6; j++) begin
      @(posedge clk2x);
      @(negedge clk2x);
      chk_idle("R2");
    end
    m1_n = 1'b1;
    @(negedge clk2x);

    // R9: a display line of 32 chained fetches, alternating mode
    begin_fetch(2'b11, 8'h07, 1'b0);
    for (int n = 0; n < 32; n++) begin
      logic [7:0] d;
      logic g;
      d = 8'(n * 7 + 3);
      g = n[0];
      begin_fetch(2'b11, d, g);
      run_pass(2'b11, d, g, 1'b0);
    end
    @(posedge clk2x);
    @(negedge clk2x);
    chk_idle("R9");

    // R3: chained non-video fetch between video ones leaves the latch alone
    begin_fetch(2'b10, 8'h99, 1'b1);
    run_pass(2'b10, 8'h99, 1'b1, 1'b0);
    begin_fetch(2'b11, 8'h5A, 1'b1);
    run_pass(2'b11, 8'h5A, 1'b1, 1'b0);
    @(posedge clk2x);
    @(negedge clk2x);
    chk_idle("R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule